// File: doc/BRIEF.md
# Flash Protected Range Guard

This block sits beside a flash sequencer and decides, for each flash access the sequencer is about to issue, whether the access must be blocked. It holds a small file of protected ranges. Each range names a first and a last 4 KiB page, and carries its own read-protect and write-protect enables. A request gives a start byte address, a byte count and a direction. The guard raises a violation flag one clock later if any byte of the request lands in a range that protects that direction. Erases count as writes.

The ranges are programmed over a simple word-wide register bus, one 32-bit word per range. A lock input freezes the whole file. From the first cycle the lock is seen until the next reset, register writes are silently dropped, so firmware can arm the protections and then make them permanent for the rest of the boot.

Top module: `flash_range_guard`

## Requirements
- R1: After reset every range word reads 0 and `viol_o` is 0.
- R2: A range word holds the first page in bits 13:0, the read-protect enable in bit 15, the last page in bits 29:16 and the write-protect enable in bit 31. Range i sits at byte offset 4*i. Bits 14 and 30 read back as 0. Offsets past the last range read 0, and writes to them change nothing.
- R3: A range covers byte addresses from first_page*4096 through last_page*4096+4095, both ends included.
- R4: A read request is flagged when any byte of it falls inside a range whose read-protect enable is set.
- R5: A write request is flagged on the same rule, using write-protect enables. A read-only range never blocks a write, and a write-only range never blocks a read.
- R6: A range with both enables clear blocks nothing, whatever its page fields hold.
- R7: A range whose first page is above its last page blocks nothing.
- R8: `viol_o` gives the verdict on the request presented in the previous cycle. It is 0 in any cycle after one in which `req_valid_i` was low.
- R9: A register write is dropped if it arrives in the cycle `lock_i` is high, or in any later cycle before reset.
- R10: `req_len_i` is the byte count minus one, so a request spans 1 to 64 bytes. A request that runs past the top of the 64 MiB address space is still judged on every page it touches below that top.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Freezes the range file until reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| req_valid_i | input | 1 | Access request present |
| req_addr_i | input | 26 | First byte address of the access |
| req_len_i | input | 6 | Byte count minus one |
| req_write_i | input | 1 | 1 for write or erase, 0 for read |
| viol_o | output | 1 | Access violation, registered |

## Verification
Four behaviours are checked on every cycle:
- the violation flag never appears without a request in the cycle before;
- the range file never changes once the lock has been seen;
- the reserved bits always read back as zero;
- a direction with no enabled range is never flagged.

The page arithmetic can only be shown by the bench's directed accesses. These cover straddling the first and last byte of a range, the inclusive 4 KiB tail, empty and disabled ranges, and an access running off the top of the address space. The bench also shows that a write arriving with the lock is dropped, and that reset releases the lock.

// File: rtl/flash_range_pkg.sv
package flash_range_pkg;
  localparam int PAGE_W     = 14;
  localparam int PAGE_SHIFT = 12;

  typedef struct packed {
    logic              wp;
    logic [PAGE_W-1:0] last;
    logic              rp;
    logic [PAGE_W-1:0] first;
  } prot_range_t;

  function automatic prot_range_t word_to_range(logic [31:0] w);
    prot_range_t r;
    r.wp    = w[31];
    r.last  = w[29:16];
    r.rp    = w[15];
    r.first = w[13:0];
    return r;
  endfunction

  function automatic logic [31:0] range_to_word(prot_range_t r);
    return {r.wp, 1'b0, r.last, r.rp, 1'b0, r.first};
  endfunction
endpackage

// File: rtl/flash_range_regs.sv
module flash_range_regs
  import flash_range_pkg::*;
#(
  parameter int NUM_RANGES = 6,
  parameter int REG_AW     = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               lock_i,
  input  logic                               we_i,
  input  logic [REG_AW-1:0]                  addr_i,
  input  logic [31:0]                        wdata_i,
  output logic [31:0]                        rdata_o,
  output prot_range_t [NUM_RANGES-1:0]       ranges_o
);
  localparam int IDX_W = REG_AW - 2;

  logic [IDX_W-1:0] idx;
  logic             lock_q;
  logic             wr_ok;
  logic             unused_lsb;

  assign idx        = addr_i[REG_AW-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign wr_ok      = we_i & ~lock_i & ~lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lock_q <= 1'b0;
    else if (lock_i) lock_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_range
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            ranges_o[g] <= '0;
      else if (wr_ok && idx == IDX_W'(g))     ranges_o[g] <= word_to_range(wdata_i);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_RANGES; i++)
      if (idx == IDX_W'(i)) rdata_o = range_to_word(ranges_o[i]);
  end
endmodule

// File: rtl/flash_range_match.sv
module flash_range_match
  import flash_range_pkg::*;
(
  input  prot_range_t       range_i,
  input  logic [PAGE_W-1:0] start_page_i,
  input  logic [PAGE_W:0]   end_page_i,
  input  logic              write_i,
  output logic              hit_o
);
  logic armed;
  logic nonempty;
  logic overlap;

  assign armed    = write_i ? range_i.wp : range_i.rp;
  assign nonempty = range_i.first <= range_i.last;
  // page-granular overlap: start <= last and end >= first
  assign overlap  = (start_page_i <= range_i.last) &&
                    (end_page_i >= {1'b0, range_i.first});
  assign hit_o    = armed & nonempty & overlap;
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
  import flash_range_pkg::*;
#(
  parameter int NUM_RANGES = 6,
  parameter int REG_AW     = 8,
  parameter int LEN_W      = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       lock_i,
  input  logic                       reg_we_i,
  input  logic [REG_AW-1:0]          reg_addr_i,
  input  logic [31:0]                reg_wdata_i,
  output logic [31:0]                reg_rdata_o,
  input  logic                       req_valid_i,
  input  logic [PAGE_W+PAGE_SHIFT-1:0] req_addr_i,
  input  logic [LEN_W-1:0]           req_len_i,
  input  logic                       req_write_i,
  output logic                       viol_o
);
  localparam int ADDR_W = PAGE_W + PAGE_SHIFT;

  prot_range_t [NUM_RANGES-1:0] ranges;
  logic [ADDR_W:0]              end_addr;
  logic [PAGE_W:0]              end_page;
  logic [PAGE_W-1:0]            start_page;
  logic [NUM_RANGES-1:0]        hits;
  logic                         viol_q;
  logic                         unused_low;

  flash_range_regs #(
    .NUM_RANGES(NUM_RANGES),
    .REG_AW    (REG_AW)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (lock_i),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ranges_o(ranges)
  );

  // one extra bit so accesses running off the top do not wrap
  assign end_addr   = {1'b0, req_addr_i} + {{(ADDR_W+1-LEN_W){1'b0}}, req_len_i};
  assign end_page   = end_addr[ADDR_W:PAGE_SHIFT];
  assign start_page = req_addr_i[ADDR_W-1:PAGE_SHIFT];
  assign unused_low = ^end_addr[PAGE_SHIFT-1:0];

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_match
    flash_range_match u_match (
      .range_i     (ranges[g]),
      .start_page_i(start_page),
      .end_page_i  (end_page),
      .write_i     (req_write_i),
      .hit_o       (hits[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= req_valid_i & (|hits);
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/flash_range_guard_sva.sv
module flash_range_guard_sva
  import flash_range_pkg::*;
#(
  parameter int NUM_RANGES = 6
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         lock_i,
  input logic                         req_valid_i,
  input logic                         req_write_i,
  input logic                         viol_o,
  input logic [31:0]                  reg_rdata_o,
  input prot_range_t [NUM_RANGES-1:0] ranges_i
);
  logic lock_seen_q;
  logic any_rp, any_wp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lock_seen_q <= 1'b0;
    else if (lock_i) lock_seen_q <= 1'b1;
  end

  always_comb begin
    any_rp = 1'b0;
    any_wp = 1'b0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      any_rp = any_rp | ranges_i[i].rp;
      any_wp = any_wp | ranges_i[i].wp;
    end
  end

  // R8
  viol_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(req_valid_i));

  // R9
  lock_freezes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i || lock_seen_q) |=> $stable(ranges_i));

  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[14] == 1'b0) && (reg_rdata_o[30] == 1'b0));

  // R4
  read_unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && !any_rp) |=> !viol_o);

  // R5
  write_unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !any_wp) |=> !viol_o);
endmodule

bind flash_range_guard flash_range_guard_sva #(.NUM_RANGES(NUM_RANGES)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lock_i     (lock_i),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .viol_o     (viol_o),
  .reg_rdata_o(reg_rdata_o),
  .ranges_i   (ranges)
);

// File: tb/flash_range_guard_tb_top.sv
module flash_range_guard_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lock_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [25:0] req_addr_i = '0;
  logic [5:0]  req_len_i = '0;
  logic        req_write_i = 1'b0;
  logic        viol_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  flash_range_guard dut_i (
    .clk_i, .rst_ni, .lock_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .req_valid_i, .req_addr_i, .req_len_i, .req_write_i, .viol_o
  );

  function automatic logic [31:0] mkr(logic [13:0] first, logic [13:0] last,
                                      logic rp, logic wp);
    return {wp, 1'b0, last, rp, 1'b0, first};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 chk(req, reg_rdata_o, exp);
  endtask

  task automatic acc_chk(string req, logic [25:0] a, logic [5:0] lm1, logic w, logic exp);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_len_i = lm1; req_write_i = w;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req, {31'b0, viol_o}, {31'b0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    #1 chk("R1 viol after reset", {31'b0, viol_o}, 0);
    for (int i = 0; i < 6; i++) rd_chk("R1 range zero", 8'(4*i), 0);
  endtask

  task automatic t_layout();
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R2 reserved bits", 8'h10, 32'hBFFF_BFFF);
    wr(8'h10, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd_chk("R2 beyond last", 8'h18, 0);
    acc_chk("R2 beyond last no effect", 26'h123_4560, 0, 1'b1, 1'b0);
  endtask

  task automatic t_read_prot();
    wr(8'h00, mkr(14'h010, 14'h01F, 1'b1, 1'b0));
    rd_chk("R2 readback", 8'h00, 32'h001F_8010);
    acc_chk("R4 first byte", 26'h001_0000, 0, 1'b0, 1'b1);
    acc_chk("R3 just below", 26'h000_FFC0, 63, 1'b0, 1'b0);
    acc_chk("R4 straddle start", 26'h000_FFF0, 31, 1'b0, 1'b1);
    acc_chk("R3 inclusive tail", 26'h001_FFFF, 0, 1'b0, 1'b1);
    acc_chk("R3 just above", 26'h002_0000, 0, 1'b0, 1'b0);
    acc_chk("R5 rp does not block write", 26'h001_5000, 7, 1'b1, 1'b0);
  endtask

  task automatic t_write_prot();
    wr(8'h04, mkr(14'h100, 14'h100, 1'b0, 1'b1));
    acc_chk("R5 write in range", 26'h010_0FF0, 15, 1'b1, 1'b1);
    acc_chk("R5 wp does not block read", 26'h010_0FF0, 15, 1'b0, 1'b0);
    acc_chk("R5 write after tail", 26'h010_1000, 0, 1'b1, 1'b0);
    acc_chk("R10 64 bytes ending below", 26'h00F_FFC0, 63, 1'b1, 1'b0);
    acc_chk("R10 64 bytes crossing in", 26'h00F_FFD0, 63, 1'b1, 1'b1);
  endtask

  task automatic t_disabled_empty();
    wr(8'h08, mkr(14'h000, 14'h3FFF, 1'b0, 1'b0));
    acc_chk("R6 no enables read", 26'h030_0000, 0, 1'b0, 1'b0);
    acc_chk("R6 no enables write", 26'h030_0000, 0, 1'b1, 1'b0);
    wr(8'h0C, mkr(14'h200, 14'h1FF, 1'b1, 1'b1));
    acc_chk("R7 inverted at last", 26'h01F_F000, 63, 1'b1, 1'b0);
    acc_chk("R7 inverted at first", 26'h020_0000, 0, 1'b0, 1'b0);
  endtask

  task automatic t_top();
    wr(8'h14, mkr(14'h3FFF, 14'h3FFF, 1'b1, 1'b1));
    acc_chk("R3 page below top", 26'h3FF_E000, 0, 1'b0, 1'b0);
    acc_chk("R4 top page", 26'h3FF_FFC0, 63, 1'b0, 1'b1);
    acc_chk("R10 runs off top", 26'h3FF_FFF0, 63, 1'b1, 1'b1);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    req_valid_i = 1'b0; req_addr_i = 26'h001_0000; req_write_i = 1'b0;
    @(negedge clk_i);
    chk("R8 no request no viol", {31'b0, viol_o}, 0);
  endtask

  task automatic t_lock();
    @(negedge clk_i);
    lock_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 8'h04; reg_wdata_i = 32'h0;
    @(negedge clk_i);
    lock_i = 1'b0; reg_we_i = 1'b0;
    rd_chk("R9 write with lock dropped", 8'h04, 32'h8100_0100);
    wr(8'h00, 32'h0);
    rd_chk("R9 write after lock dropped", 8'h00, 32'h001F_8010);
    acc_chk("R9 protection kept", 26'h001_0000, 0, 1'b0, 1'b1);
    do_reset();
    rd_chk("R1 reset clears ranges", 8'h00, 0);
    wr(8'h00, mkr(14'h001, 14'h002, 1'b1, 1'b0));
    rd_chk("R9 reset releases lock", 8'h00, 32'h0002_8001);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_layout();
    t_read_prot();
    t_write_prot();
    t_disabled_empty();
    t_top();
    t_idle();
    t_lock();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule